// File: doc/BRIEF.md
# Parallel NOR Flash Command Front-End

This block is a clock-synchronous model of the bus side of a parallel NOR flash device. Every cycle it samples the device pins: chip enable, write enable, output enable, a hardware reset pin, a bus-width select pin and the address. The 16-bit data bus is split into an input half, an output half and a per-bit output enable. Bus writes are decoded as command sequences. These sequences move the device between array reading, identification reading, a shortened program mode and a busy state in which a program or erase runs for a set number of clock cycles.

A small internal RAM stands in for the flash array. Programming can only clear bits, so a stored word becomes the old value ANDed with the new data. Erasing sets words back to all ones. In narrow (8-bit) mode only the low eight data lines are driven. The top data line then becomes an input that selects the upper or lower byte of the addressed word.

Top module: `nor_cmd_frontend`

## Requirements
- R1: With `word_mode`=1, `ce_n`=0, `oe_n`=0, `we_n`=1 and `pin_rst_n`=1, outside the identification and busy states, `dq_oe`=16'hFFFF and `dq_out` equals the stored word at `addr[ARRAY_AW-1:0]`, in the same cycle.
- R2: With `word_mode`=0 and the same read conditions, `dq_oe`=16'h00FF. `dq_out[7:0]` is the upper byte of the addressed word when `dq_in[15]`=1 and the lower byte when it is 0. `dq_out[15:8]` is 0.
- R3: If `ce_n`=1, `oe_n`=1 or `we_n`=0, `dq_oe` is 0.
- R4: After `rst`, every word reads 16'hFFFF and the block is in array-read mode with no command needed.
- R5: A bus write is taken once, in the cycle in which `ce_n`=0, `we_n`=0 and `oe_n`=1 first hold together. The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data@A start a program. Command addresses are `addr[10:0]` and command bytes are `dq_in[7:0]`. After PROG_CYCLES cycles the word (or, in 8-bit mode, the byte chosen by `dq_in[15]`) holds old AND data.
- R6: While busy, reads return 0 on `dq_out[15:8]` and on `dq_out[5:0]`. `dq_out[7]` is the complement of data bit 7 for a program and 0 for an erase. `dq_out[6]` differs between two consecutive reads and stays stable within one read.
- R7: The writes 0xAA@0x555, 0x55@0x2AA and 0x90@0x555 enter identification mode. There, reads give MFR_ID when `addr[1:0]`=0, DEV_ID when it is 1, and 0 otherwise, all on `dq_out[7:0]`. Any write other than an unlock start returns the block to array reading.
- R8: The writes 0xAA@0x555, 0x55@0x2AA and 0x20@0x555 enter the short-program mode. In that mode, 0xA0 followed by data@A programs in two writes, and the block comes back to this mode afterwards. A write other than 0xA0 leaves the mode.
- R9: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30@A set every word in the sector of A (the top SECTOR_AW bits of the word index) to 16'hFFFF after ERASE_CYCLES cycles. Other words are left unchanged.
- R10: The same sequence ending in 0x10@0x555 sets every word to 16'hFFFF.
- R11: A wrong address or data anywhere in a sequence returns the block to array reading with no change to the array. A write attempted while `oe_n`=0 is not taken.
- R12: Raising `ce_n` during a program or erase, or making write attempts while busy, does not stop or alter the running operation.
- R13: While `pin_rst_n`=0, `dq_oe` is 0, writes are ignored and a running operation is aborted without changing the array. After release the block is in array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fills the array with ones |
| pin_rst_n | input | 1 | Device hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Word address; low 11 bits decode commands |
| dq_in | input | 16 | Data bus input; bit 15 is the byte select in 8-bit mode |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-bit output enable of the data bus |

## Verification
The hardest situations to reach are a hardware reset, a `ce_n` release or stray write attempts that land while the multi-cycle program or erase is still running. Status reads that must alternate bit 6 also have to fall inside the busy window. The bench times its bus tasks so that two status reads, the idle `ce_n` stretch and a pin-reset pulse all fall inside the PROG_CYCLES window. Each of these is followed by array reads that show whether the operation finished or was dropped. Random programs in both bus widths build a mixed array before the sector erase, so the words left alone can be told apart from erased ones.

// File: rtl/nor_fe_pkg.sv
package nor_fe_pkg;

    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] UNL_ADDR_B = 11'h2AA;
    localparam logic [7:0] CMD_UNL_A   = 8'hAA;
    localparam logic [7:0] CMD_UNL_B   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_FASTPRG = 8'h20;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PROG_DATA,
        ST_ERA0,
        ST_ERA1,
        ST_ERA2,
        ST_IDENT,
        ST_FAST,
        ST_FAST_DATA,
        ST_BUSY
    } fe_state_t;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_t;

    typedef struct packed {
        op_kind_t    kind;
        logic        narrow;
        logic        hi_byte;
        logic [15:0] data;
    } op_req_t;

    function automatic logic first_unlock(input logic [CMD_AW-1:0] a, input logic [7:0] d);
        return (a == UNL_ADDR_A) && (d == CMD_UNL_A);
    endfunction

    function automatic logic second_unlock(input logic [CMD_AW-1:0] a, input logic [7:0] d);
        return (a == UNL_ADDR_B) && (d == CMD_UNL_B);
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst_n,
    input  logic              wr_stb,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              op_done,
    output fe_state_t         state,
    output logic              op_start,
    output op_kind_t          op_kind
);

    fe_state_t state_q, state_d;
    logic      ret_fast_q, ret_fast_d;

    always_comb begin
        state_d    = state_q;
        ret_fast_d = ret_fast_q;
        op_start   = 1'b0;
        op_kind    = OP_PROG;
        if (state_q == ST_BUSY) begin
            if (op_done) state_d = ret_fast_q ? ST_FAST : ST_READ;
        end else if (wr_stb) begin
            unique case (state_q)
                ST_READ, ST_IDENT:
                    state_d = first_unlock(cmd_addr, cmd_data) ? ST_UNL1 : ST_READ;
                ST_UNL1:
                    state_d = second_unlock(cmd_addr, cmd_data) ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    state_d = ST_READ;
                    if (cmd_addr == UNL_ADDR_A) begin
                        case (cmd_data)
                            CMD_PROG:    state_d = ST_PROG_DATA;
                            CMD_IDENT:   state_d = ST_IDENT;
                            CMD_FASTPRG: state_d = ST_FAST;
                            CMD_ERASE:   state_d = ST_ERA0;
                            default:     state_d = ST_READ;
                        endcase
                    end
                end
                ST_PROG_DATA: begin
                    op_start   = 1'b1;
                    ret_fast_d = 1'b0;
                    state_d    = ST_BUSY;
                end
                ST_ERA0:
                    state_d = first_unlock(cmd_addr, cmd_data) ? ST_ERA1 : ST_READ;
                ST_ERA1:
                    state_d = second_unlock(cmd_addr, cmd_data) ? ST_ERA2 : ST_READ;
                ST_ERA2: begin
                    state_d = ST_READ;
                    if (cmd_data == CMD_CHIP && cmd_addr == UNL_ADDR_A) begin
                        op_start   = 1'b1;
                        op_kind    = OP_CHIP;
                        ret_fast_d = 1'b0;
                        state_d    = ST_BUSY;
                    end else if (cmd_data == CMD_SECT) begin
                        op_start   = 1'b1;
                        op_kind    = OP_SECT;
                        ret_fast_d = 1'b0;
                        state_d    = ST_BUSY;
                    end
                end
                ST_FAST:
                    state_d = (cmd_data == CMD_PROG) ? ST_FAST_DATA : ST_READ;
                ST_FAST_DATA: begin
                    op_start   = 1'b1;
                    ret_fast_d = 1'b1;
                    state_d    = ST_BUSY;
                end
                default: state_d = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pin_rst_n) begin
            state_q    <= ST_READ;
            ret_fast_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ret_fast_q <= ret_fast_d;
        end
    end

    assign state = state_q;

    assert_pin_reset_read_R13: assert property (@(posedge clk) disable iff (rst)
        !pin_rst_n |=> state_q == ST_READ);

    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && !op_done && pin_rst_n) |=> state_q == ST_BUSY);

    assert_start_enters_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (op_start && pin_rst_n) |=> state_q == ST_BUSY);

endmodule

// File: rtl/nor_array_engine.sv
module nor_array_engine
    import nor_fe_pkg::*;
#(
    parameter int ARRAY_AW     = 6,
    parameter int SECTOR_AW    = 2,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                abort,
    input  logic                start,
    input  op_req_t             req,
    input  logic [ARRAY_AW-1:0] req_word,
    input  logic [ARRAY_AW-1:0] rd_word,
    output logic [15:0]         rd_data,
    output logic                busy,
    output logic                done,
    output logic                status_d7
);

    localparam int WORDS   = 1 << ARRAY_AW;
    localparam int MAXC    = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAXC + 1);
    localparam int SEC_SH  = ARRAY_AW - SECTOR_AW;

    logic [15:0]         mem [WORDS];
    logic                busy_q;
    logic [CNT_W-1:0]    cnt_q;
    op_req_t             op_q;
    logic [ARRAY_AW-1:0] word_q;
    logic [CNT_W-1:0]    limit;

    assign limit   = (op_q.kind == OP_PROG) ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);
    assign done    = busy_q && !abort && (cnt_q == limit);
    assign busy    = busy_q;
    assign rd_data = mem[rd_word];
    assign status_d7 = (op_q.kind == OP_PROG) ? ~op_q.data[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= '0;
            word_q <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            op_q   <= req;
            word_q <= req_word;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
                unique case (op_q.kind)
                    OP_PROG: begin
                        if (!op_q.narrow)
                            mem[word_q] <= mem[word_q] & op_q.data;
                        else if (op_q.hi_byte)
                            mem[word_q][15:8] <= mem[word_q][15:8] & op_q.data[7:0];
                        else
                            mem[word_q][7:0] <= mem[word_q][7:0] & op_q.data[7:0];
                    end
                    OP_SECT: begin
                        for (int i = 0; i < WORDS; i++)
                            if ((i >> SEC_SH) == int'(word_q >> SEC_SH)) mem[i] <= 16'hFFFF;
                    end
                    default: begin
                        for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
                    end
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_start_runs_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !abort && !busy_q) |=> busy_q);

    assert_end_cause_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(done) || $past(abort)));

endmodule

// File: rtl/nor_bus_drive.sv
module nor_bus_drive
    import nor_fe_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h37,
    parameter logic [7:0] DEV_ID = 8'hC4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_rst_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        word_mode,
    input  logic        hi_byte,
    input  logic [1:0]  id_sel,
    input  fe_state_t   state,
    input  logic [15:0] arr_data,
    input  logic        status_d7,
    output logic [15:0] dq_out,
    output logic [15:0] dq_oe
);

    logic rd_now, rd_q, tog_q;
    logic [7:0] id_byte;

    assign rd_now = pin_rst_n && !ce_n && !oe_n && we_n;

    always_comb begin
        case (id_sel)
            2'd0:    id_byte = MFR_ID;
            2'd1:    id_byte = DEV_ID;
            default: id_byte = 8'h00;
        endcase
    end

    always_comb begin
        dq_out = '0;
        case (state)
            ST_IDENT: dq_out[7:0] = id_byte;
            ST_BUSY:  dq_out[7:0] = {status_d7, tog_q, 6'b0};
            default: begin
                if (word_mode)    dq_out = arr_data;
                else if (hi_byte) dq_out[7:0] = arr_data[15:8];
                else              dq_out[7:0] = arr_data[7:0];
            end
        endcase
    end

    assign dq_oe = !rd_now ? 16'h0000 : (word_mode ? 16'hFFFF : 16'h00FF);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
            if (rd_q && !rd_now && state == ST_BUSY) tog_q <= ~tog_q;
        end
    end

    assert_reset_pin_hiz_R13: assert property (@(posedge clk) disable iff (rst)
        !pin_rst_n |-> dq_oe == 16'h0000);

    assert_narrow_upper_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> dq_oe[15:8] == 8'h00);

    assert_status_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_now && rd_q && state == ST_BUSY && $past(state) == ST_BUSY) |-> $stable(tog_q));

endmodule

// File: rtl/nor_cmd_frontend.sv
module nor_cmd_frontend
    import nor_fe_pkg::*;
#(
    parameter int         ADDR_W       = 11,
    parameter int         ARRAY_AW     = 6,
    parameter int         SECTOR_AW    = 2,
    parameter int         PROG_CYCLES  = 12,
    parameter int         ERASE_CYCLES = 40,
    parameter logic [7:0] MFR_ID       = 8'h37,
    parameter logic [7:0] DEV_ID       = 8'hC4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);

    logic      wr_now, wr_q, wr_stb;
    fe_state_t state;
    logic      op_start, op_done, busy, status_d7;
    op_kind_t  op_kind;
    op_req_t   req;
    logic [15:0] arr_data;

    assign wr_now = pin_rst_n && !ce_n && !we_n && oe_n;
    assign wr_stb = wr_now && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= wr_now;
    end

    assign req.kind    = op_kind;
    assign req.narrow  = !word_mode;
    assign req.hi_byte = dq_in[15];
    assign req.data    = word_mode ? dq_in : {8'h00, dq_in[7:0]};

    nor_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .pin_rst_n(pin_rst_n),
        .wr_stb   (wr_stb),
        .cmd_addr (addr[CMD_AW-1:0]),
        .cmd_data (dq_in[7:0]),
        .op_done  (op_done),
        .state    (state),
        .op_start (op_start),
        .op_kind  (op_kind)
    );

    nor_array_engine #(
        .ARRAY_AW    (ARRAY_AW),
        .SECTOR_AW   (SECTOR_AW),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .abort    (!pin_rst_n),
        .start    (op_start),
        .req      (req),
        .req_word (addr[ARRAY_AW-1:0]),
        .rd_word  (addr[ARRAY_AW-1:0]),
        .rd_data  (arr_data),
        .busy     (busy),
        .done     (op_done),
        .status_d7(status_d7)
    );

    nor_bus_drive #(
        .MFR_ID(MFR_ID),
        .DEV_ID(DEV_ID)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .pin_rst_n(pin_rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .word_mode(word_mode),
        .hi_byte  (dq_in[15]),
        .id_sel   (addr[1:0]),
        .state    (state),
        .arr_data (arr_data),
        .status_d7(status_d7),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    assert_busy_matches_state_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY) |-> busy);

endmodule

// File: tb/nor_cmd_frontend_bench.sv
module nor_cmd_frontend_bench;

    localparam int PROG_C  = 12;
    localparam int ERASE_C = 40;
    localparam int WORDS   = 64;
    localparam logic [7:0] MFR = 8'h37;
    localparam logic [7:0] DEV = 8'hC4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_rst_n = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic word_mode = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;

    logic [15:0] model [WORDS];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nor_cmd_frontend #(
        .ADDR_W(11), .ARRAY_AW(6), .SECTOR_AW(2),
        .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C),
        .MFR_ID(MFR), .DEV_ID(DEV)
    ) u_nor_cmd_frontend (
        .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .word_mode(word_mode),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int a, input logic wm, input logic hi);
        if (wm) return model[a];
        return hi ? {8'h00, model[a][15:8]} : {8'h00, model[a][7:0]};
    endfunction

    function automatic void model_prog(input int a, input logic wm, input logic hi, input logic [15:0] d);
        if (wm)      model[a] = model[a] & d;
        else if (hi) model[a][15:8] = model[a][15:8] & d[7:0];
        else         model[a][7:0]  = model[a][7:0] & d[7:0];
    endfunction

    task automatic bus_wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 0; oe_n = 1; we_n = 0; addr = a; dq_in = d;
        @(negedge clk);
        we_n = 1; ce_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [10:0] a, input logic hi, output logic [15:0] q, output logic [15:0] en);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a; dq_in = {hi, 15'h0};
        @(negedge clk);
        q = dq_out; en = dq_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic unlock();
        bus_wr(11'h555, 16'h00AA);
        bus_wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog_std(input int a, input logic hi, input logic [15:0] d);
        unlock();
        bus_wr(11'h555, 16'h00A0);
        bus_wr(11'(a), word_mode ? d : {hi, 7'h0, d[7:0]});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input int a, input logic hi);
        logic [15:0] q, en;
        bus_rd(11'(a), hi, q, en);
        check(req, q, exp_read(a, word_mode, hi));
        check(req, en, word_mode ? 16'hFFFF : 16'h00FF);
    endtask

    task automatic sweep(input string req);
        logic [15:0] q, en;
        for (int i = 0; i < WORDS; i++) begin
            bus_rd(11'(i), 1'b0, q, en);
            check(req, q, model[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] q, en, q2;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        wait_cyc(4);
        rst = 0;
        wait_cyc(2);

        // R4: reset contents, array mode without a command
        read_chk("R4 reset read", 5, 1'b0);
        read_chk("R4 reset read", 63, 1'b0);

        // R3: outputs off without a full read condition
        @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1;
        @(negedge clk); check("R3 ce high", dq_oe, 16'h0000);
        ce_n = 0; oe_n = 1;
        @(negedge clk); check("R3 oe high", dq_oe, 16'h0000);
        ce_n = 1;

        // R5 + R6: standard program with status reads
        prog_std(3, 1'b0, 16'h1234);
        bus_rd(11'd3, 1'b0, q, en);
        check("R6 status d7", {8'h00, q[7], 7'h0}, {8'h00, ~1'b0, 7'h0});
        check("R6 status zero bits", q & 16'hFF3F, 16'h0000);
        bus_rd(11'd3, 1'b0, q2, en);
        check("R6 toggle", {15'h0, q2[6]}, {15'h0, ~q[6]});
        wait_cyc(PROG_C + 4);
        model_prog(3, 1'b1, 1'b0, 16'h1234);
        read_chk("R1 word read after R5 program", 3, 1'b0);
        // R5: second program only clears bits
        prog_std(3, 1'b0, 16'hF0F0);
        wait_cyc(PROG_C + 4);
        model_prog(3, 1'b1, 1'b0, 16'hF0F0);
        read_chk("R5 and semantics", 3, 1'b0);

        // R2: narrow mode byte program and reads
        word_mode = 0;
        prog_std(7, 1'b1, 16'h005A);
        wait_cyc(PROG_C + 4);
        model_prog(7, 1'b0, 1'b1, 16'h005A);
        read_chk("R2 byte hi", 7, 1'b1);
        read_chk("R2 byte lo", 7, 1'b0);
        read_chk("R2 byte word3 hi", 3, 1'b1);
        word_mode = 1;

        // R7: identification mode
        unlock();
        bus_wr(11'h555, 16'h0090);
        bus_rd(11'd0, 1'b0, q, en);
        check("R7 mfr id", q, {8'h00, MFR});
        bus_rd(11'd1, 1'b0, q, en);
        check("R7 dev id", q, {8'h00, DEV});
        bus_rd(11'd2, 1'b0, q, en);
        check("R7 other id", q, 16'h0000);
        bus_wr(11'd0, 16'h00F0);
        read_chk("R7 back to array", 3, 1'b0);

        // R8: short program mode
        unlock();
        bus_wr(11'h555, 16'h0020);
        bus_wr(11'd0, 16'h00A0);
        bus_wr(11'd10, 16'h8001);
        wait_cyc(PROG_C + 4);
        model_prog(10, 1'b1, 1'b0, 16'h8001);
        bus_wr(11'd0, 16'h00A0);
        bus_wr(11'd11, 16'h4002);
        wait_cyc(PROG_C + 4);
        model_prog(11, 1'b1, 1'b0, 16'h4002);
        read_chk("R8 fast prog 1", 10, 1'b0);
        read_chk("R8 fast prog 2", 11, 1'b0);
        bus_wr(11'd0, 16'h0000);
        bus_wr(11'd0, 16'h00A0);
        bus_wr(11'd12, 16'h0000);
        wait_cyc(PROG_C + 4);
        read_chk("R8 exit leaves array", 12, 1'b0);

        // R11: broken sequence and write with oe low
        bus_wr(11'h555, 16'h00AA);
        bus_wr(11'h123, 16'h0055);
        bus_wr(11'h555, 16'h00A0);
        bus_wr(11'd13, 16'h0000);
        wait_cyc(PROG_C + 4);
        read_chk("R11 bad address", 13, 1'b0);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 11'h555; dq_in = 16'h00AA;
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
        bus_wr(11'h2AA, 16'h0055);
        bus_wr(11'h555, 16'h00A0);
        bus_wr(11'd14, 16'h0000);
        wait_cyc(PROG_C + 4);
        read_chk("R11 oe low write", 14, 1'b0);

        // R12: ce high and write attempts during busy
        prog_std(20, 1'b0, 16'h0F0F);
        @(negedge clk); ce_n = 1; oe_n = 0; we_n = 0; addr = 11'h555; dq_in = 16'h00F0;
        @(negedge clk); check("R3 R12 ce high no drive", dq_oe, 16'h0000);
        we_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 0; we_n = 0; dq_in = 16'h00F0;
        @(negedge clk); ce_n = 1; we_n = 1;
        wait_cyc(PROG_C + 4);
        model_prog(20, 1'b1, 1'b0, 16'h0F0F);
        read_chk("R12 completes", 20, 1'b0);

        // R13: pin reset aborts a program
        prog_std(21, 1'b0, 16'h0000);
        @(negedge clk); pin_rst_n = 0; ce_n = 0; oe_n = 0; we_n = 1; addr = 11'd21;
        @(negedge clk); check("R13 hiz in reset", dq_oe, 16'h0000);
        wait_cyc(PROG_C + 2);
        ce_n = 1; oe_n = 1; pin_rst_n = 1;
        wait_cyc(2);
        read_chk("R13 aborted program", 21, 1'b0);

        // Random programs in both widths
        for (int it = 0; it < 30; it++) begin
            int a;
            logic hi, wm;
            logic [15:0] d;
            a  = int'($urandom_range(0, WORDS - 1));
            wm = 1'($urandom_range(0, 1));
            hi = 1'($urandom_range(0, 1));
            d  = 16'($urandom());
            word_mode = wm;
            prog_std(a, hi, d);
            wait_cyc(PROG_C + 4);
            model_prog(a, wm, hi, d);
            read_chk("R5 random program", a, hi);
            read_chk("R2 R1 random read", int'($urandom_range(0, WORDS - 1)), 1'($urandom_range(0, 1)));
        end
        word_mode = 1;
        model_prog(16, 1'b1, 1'b0, 16'h0000);
        prog_std(16, 1'b0, 16'h0000);
        wait_cyc(PROG_C + 4);
        model_prog(40, 1'b1, 1'b0, 16'h1111);
        prog_std(40, 1'b0, 16'h1111);
        wait_cyc(PROG_C + 4);

        // R9: sector erase of words 16..31
        unlock();
        bus_wr(11'h555, 16'h0080);
        unlock();
        bus_wr(11'd17, 16'h0030);
        bus_rd(11'd17, 1'b0, q, en);
        check("R9 erase status d7", {15'h0, q[7]}, 16'h0000);
        wait_cyc(ERASE_C + 4);
        for (int i = 16; i < 32; i++) model[i] = 16'hFFFF;
        sweep("R9 sector erase");

        // R10: chip erase
        unlock();
        bus_wr(11'h555, 16'h0080);
        unlock();
        bus_wr(11'h555, 16'h0010);
        wait_cyc(ERASE_C + 4);
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        sweep("R10 chip erase");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule